// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a soft, cycle-based model of a small programmable sum-of-products device. Ten pins feed an AND plane together with eight feedback signals; each of eight output cells owns eight product terms. Each cell either drives the OR of its terms straight to its pad or captures that OR in a flip-flop clocked by pin 0. Its pad enable comes from a dedicated product term or from pin 9 as a shared active-low enable. Three pins do double duty: pin 0 (register clock), pin 9 (shared enable) and pin 3 (power-down request). A configuration bit decides, for each of them, whether it serves that role or is an ordinary array input.

A host loads the fuse rows and a control word through a parallel write port, then operates the array. Every register in the block runs on the system clock `clk`. Pin 0 is sampled on `clk`, and its rising transitions act as the register clock of the array. When power-down is enabled and pin 3 is high, the pads freeze: driven pads keep their level, released pads stay released, and neither pin edges nor input changes affect any state. `ioIn` is the sampled pad level of each cell, which combinational cells feed back into the array.

Top module: `pal_logic_array`

## Requirements
- R1: After reset every fuse row, the control word, the cell registers and the frozen-output copies are zero. The array then runs in mode 0 with all terms empty (true), so `ioOut` and `ioOe` both read 8'hFF.
- R2: A write with `cfgAddr` = cell*8+term stores fuse row `cfgData` for that term. Signal k (k=0..9 is `pinIn[k]`, k=10..17 is the feedback of cell k-10) has its true literal at fuse bit 2k and its complement at bit 2k+1. A term is the AND of the literals whose fuse bit is 1. A term with no literal is true, and a term with every literal set is false.
- R3: A combinational cell drives the pad enable from its term 0 and drives `ioOut` with the OR of terms 1..7 XOR its polarity bit. Its feedback signal is `ioIn` of that cell.
- R4: A registered cell loads the OR of all eight terms XOR its polarity bit on each rising transition of `pinIn[0]` seen on `clk`. `ioOut` shows the register, the pad enable is the inverse of `pinIn[9]`, and the feedback is the register value.
- R5: A write to address 64 sets the control word: bits [1:0] select the mode (0 all combinational, 1 all registered, 2 or 3 mixed with bits [10:3] marking the registered cells), bit 2 enables power-down, and bits [18:11] hold the per-cell polarity. Writes to addresses above 64 change nothing.
- R6: In modes 1 to 3 both literals of pins 0 and 9 read as true inside the array. With power-down enabled, both literals of pin 3 read as true.
- R7: With power-down disabled, pin 3 is an ordinary array input.
- R8: With power-down enabled and `pinIn[3]` high, `ioOut` and `ioOe` equal their values from the last `clk` cycle before the freeze began.
- R9: While frozen, no register loads. A `pinIn[0]` rise that occurs during the freeze is lost.
- R10: When the freeze ends, the pads follow the array in that same cycle. Registers keep their value until the next rising transition of `pinIn[0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state and pin-0 sampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 7 | Fuse row (0..63) or control word (64) |
| cfgData | input | 36 | Fuse row contents or control word |
| pinIn | input | 10 | Dedicated input pins; 0 clock, 3 power-down, 9 shared enable |
| ioIn | input | 8 | Sampled pad level of each cell |
| ioOut | output | 8 | Value each cell drives onto its pad |
| ioOe | output | 8 | Pad enable of each cell, active high |

## Verification
Power-down entry and a register clock edge can land in the same `clk` cycle. The same holds for power-down release and an edge. In each case the freeze must win: the edge is lost, and the register waits for a fresh rise after release. The bench toggles the power-down pin at random in runs of a few cycles while `pinIn[0]` toggles at random every cycle, so both collisions occur many times in each mode. A behavioural model judges the result, keeping its own copy of the last unfrozen pad values and its own previous pin-0 level. A directed sequence additionally places a rise of pin 0 exactly in the entry cycle and checks that the register keeps its value through release until the next rise.

// File: rtl/pal_pkg.sv
package pal_pkg;

  typedef enum logic [1:0] {
    MODE_COMB = 2'd0,
    MODE_REG  = 2'd1,
    MODE_MIX  = 2'd2,
    MODE_MIXB = 2'd3
  } palMode_e;

  typedef struct packed {
    logic regLoad;
    logic holdLoad;
    logic freeze;
  } palStrobe_t;

endpackage

// File: rtl/pal_cfg_store.sv
module pal_cfg_store
  import pal_pkg::*;
#(
  parameter int N_IN   = 10,
  parameter int N_CELL = 8,
  parameter int N_TERM = 8,
  localparam int N_ROW = N_CELL * N_TERM,
  localparam int LIT_W = 2 * (N_IN + N_CELL),
  localparam int AW    = $clog2(N_ROW + 1),
  localparam int RW    = $clog2(N_ROW)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfgWe,
  input  logic [AW-1:0]          cfgAddr,
  input  logic [LIT_W-1:0]       cfgData,
  output logic [N_ROW*LIT_W-1:0] fuseFlat,
  output palMode_e               mode,
  output logic                   pdEn,
  output logic [N_CELL-1:0]      regSel,
  output logic [N_CELL-1:0]      pol
);

  localparam logic [AW-1:0] CTRL_ADDR = AW'(N_ROW);

  logic [LIT_W-1:0] fuseRow [N_ROW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < N_ROW; r++) fuseRow[r] <= '0;
      mode   <= MODE_COMB;
      pdEn   <= 1'b0;
      regSel <= '0;
      pol    <= '0;
    end else if (cfgWe) begin
      if (cfgAddr < CTRL_ADDR) begin
        fuseRow[cfgAddr[RW-1:0]] <= cfgData;
      end else if (cfgAddr == CTRL_ADDR) begin
        mode   <= palMode_e'(cfgData[1:0]);
        pdEn   <= cfgData[2];
        regSel <= cfgData[3 +: N_CELL];
        pol    <= cfgData[3+N_CELL +: N_CELL];
      end
    end
  end

  for (genvar r = 0; r < N_ROW; r++) begin : g_flat
    assign fuseFlat[r*LIT_W +: LIT_W] = fuseRow[r];
  end

endmodule

// File: rtl/pal_ctrl.sv
module pal_ctrl
  import pal_pkg::*;
#(
  parameter int N_IN    = 10,
  parameter int CLK_PIN = 0,
  parameter int OE_PIN  = 9,
  parameter int PD_PIN  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pinClk,
  input  logic            pinPd,
  input  palMode_e        mode,
  input  logic            pdEn,
  output palStrobe_t      strobe,
  output logic [N_IN-1:0] pinMask
);

  logic clkPrev;
  logic freeze;

  assign freeze = pdEn & pinPd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clkPrev <= 1'b0;
    else        clkPrev <= pinClk;
  end

  always_comb begin
    strobe.freeze   = freeze;
    strobe.holdLoad = ~freeze;
    strobe.regLoad  = pinClk & ~clkPrev & ~freeze & (mode != MODE_COMB);
  end

  always_comb begin
    pinMask = '0;
    if (mode != MODE_COMB) begin
      pinMask[CLK_PIN] = 1'b1;
      pinMask[OE_PIN]  = 1'b1;
    end
    if (pdEn) pinMask[PD_PIN] = 1'b1;
  end

endmodule

// File: rtl/pal_datapath.sv
module pal_datapath
  import pal_pkg::*;
#(
  parameter int N_IN   = 10,
  parameter int N_CELL = 8,
  parameter int N_TERM = 8,
  parameter int OE_PIN = 9,
  localparam int N_SIG = N_IN + N_CELL,
  localparam int LIT_W = 2 * N_SIG,
  localparam int N_ROW = N_CELL * N_TERM
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_IN-1:0]        pinIn,
  input  logic [N_CELL-1:0]      ioIn,
  input  logic [N_ROW*LIT_W-1:0] fuseFlat,
  input  palMode_e               mode,
  input  logic [N_CELL-1:0]      regSel,
  input  logic [N_CELL-1:0]      pol,
  input  logic [N_IN-1:0]        pinMask,
  input  palStrobe_t             strobe,
  output logic [N_CELL-1:0]      ioOut,
  output logic [N_CELL-1:0]      ioOe,
  output logic [N_CELL-1:0]      regQ
);

  logic [N_CELL-1:0] isReg, fb, cellD, liveOut, liveOe, holdOut, holdOe;
  logic [N_SIG-1:0]  sig, sigMask;
  logic [LIT_W-1:0]  lit;
  logic [N_ROW-1:0]  termHit;

  always_comb begin
    for (int c = 0; c < N_CELL; c++) begin
      isReg[c] = (mode == MODE_REG) |
                 (((mode == MODE_MIX) | (mode == MODE_MIXB)) & regSel[c]);
    end
  end

  // registered cells feed back their flop, combinational cells their pad
  assign fb      = (isReg & regQ) | (~isReg & ioIn);
  assign sig     = {fb, pinIn};
  assign sigMask = {{N_CELL{1'b0}}, pinMask};

  for (genvar k = 0; k < N_SIG; k++) begin : g_lit
    assign lit[2*k]   =  sig[k] | sigMask[k];
    assign lit[2*k+1] = ~sig[k] | sigMask[k];
  end

  // an unconnected literal contributes a one to the AND
  for (genvar r = 0; r < N_ROW; r++) begin : g_term
    assign termHit[r] = &(lit | ~fuseFlat[r*LIT_W +: LIT_W]);
  end

  for (genvar c = 0; c < N_CELL; c++) begin : g_cell
    logic [N_TERM-1:0] cellTerms;
    logic              sumAll, sumTail;
    assign cellTerms  = termHit[c*N_TERM +: N_TERM];
    assign sumAll     = |cellTerms;
    assign sumTail    = |cellTerms[N_TERM-1:1];
    assign cellD[c]   = sumAll ^ pol[c];
    assign liveOut[c] = isReg[c] ? regQ[c] : (sumTail ^ pol[c]);
    assign liveOe[c]  = isReg[c] ? ~pinIn[OE_PIN] : cellTerms[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regQ <= '0;
    end else if (strobe.regLoad) begin
      regQ <= (isReg & cellD) | (~isReg & regQ);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdOut <= '0;
      holdOe  <= '0;
    end else if (strobe.holdLoad) begin
      holdOut <= liveOut;
      holdOe  <= liveOe;
    end
  end

  assign ioOut = strobe.freeze ? holdOut : liveOut;
  assign ioOe  = strobe.freeze ? holdOe  : liveOe;

endmodule

// File: rtl/pal_logic_array.sv
module pal_logic_array
  import pal_pkg::*;
#(
  parameter int N_IN    = 10,
  parameter int N_CELL  = 8,
  parameter int N_TERM  = 8,
  parameter int CLK_PIN = 0,
  parameter int OE_PIN  = 9,
  parameter int PD_PIN  = 3,
  localparam int LIT_W  = 2 * (N_IN + N_CELL),
  localparam int N_ROW  = N_CELL * N_TERM,
  localparam int AW     = $clog2(N_ROW + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWe,
  input  logic [AW-1:0]     cfgAddr,
  input  logic [LIT_W-1:0]  cfgData,
  input  logic [N_IN-1:0]   pinIn,
  input  logic [N_CELL-1:0] ioIn,
  output logic [N_CELL-1:0] ioOut,
  output logic [N_CELL-1:0] ioOe
);

  logic [N_ROW*LIT_W-1:0] fuseFlat;
  palMode_e               cfgMode;
  logic                   cfgPdEn;
  logic [N_CELL-1:0]      cfgRegSel, cfgPol, regQ;
  logic [N_IN-1:0]        pinMask;
  palStrobe_t             strobe;

  pal_cfg_store #(.N_IN(N_IN), .N_CELL(N_CELL), .N_TERM(N_TERM)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .fuseFlat(fuseFlat), .mode(cfgMode), .pdEn(cfgPdEn), .regSel(cfgRegSel), .pol(cfgPol)
  );

  pal_ctrl #(.N_IN(N_IN), .CLK_PIN(CLK_PIN), .OE_PIN(OE_PIN), .PD_PIN(PD_PIN)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pinClk(pinIn[CLK_PIN]), .pinPd(pinIn[PD_PIN]),
    .mode(cfgMode), .pdEn(cfgPdEn), .strobe(strobe), .pinMask(pinMask)
  );

  pal_datapath #(.N_IN(N_IN), .N_CELL(N_CELL), .N_TERM(N_TERM), .OE_PIN(OE_PIN)) u_dp (
    .clk(clk), .rst_n(rst_n), .pinIn(pinIn), .ioIn(ioIn), .fuseFlat(fuseFlat),
    .mode(cfgMode), .regSel(cfgRegSel), .pol(cfgPol), .pinMask(pinMask), .strobe(strobe),
    .ioOut(ioOut), .ioOe(ioOe), .regQ(regQ)
  );

endmodule

// File: rtl/pal_logic_array_chk.sv
module pal_logic_array_chk #(
  parameter int N_CELL = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pinClk,
  input logic              pinOe,
  input logic              pinPd,
  input logic [1:0]        modeBits,
  input logic              pdEn,
  input logic [N_CELL-1:0] regQ,
  input logic [N_CELL-1:0] ioOut,
  input logic [N_CELL-1:0] ioOe
);

  logic [1:0] armCnt;
  logic       frozen;

  assign frozen = pdEn & pinPd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              armCnt <= 2'd0;
    else if (armCnt != 2'd3) armCnt <= armCnt + 2'd1;
  end

  a_r8_pads_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (armCnt != 2'd0) && frozen && $past(frozen) |-> $stable(ioOut) && $stable(ioOe));

  a_r9_no_load_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(regQ));

  a_r4_load_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (armCnt >= 2'd2) && (regQ != $past(regQ)) |-> $past(pinClk) && !$past(pinClk, 2));

  a_r4_reg_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !frozen && (modeBits == 2'd1) |-> ioOe == {N_CELL{~pinOe}});

  a_r4_reg_output: assert property (@(posedge clk) disable iff (!rst_n)
    !frozen && (modeBits == 2'd1) |-> ioOut == regQ);

endmodule

bind pal_logic_array pal_logic_array_chk #(.N_CELL(N_CELL)) u_chk (
  .clk(clk), .rst_n(rst_n), .pinClk(pinIn[CLK_PIN]), .pinOe(pinIn[OE_PIN]),
  .pinPd(pinIn[PD_PIN]), .modeBits(cfgMode), .pdEn(cfgPdEn), .regQ(regQ),
  .ioOut(ioOut), .ioOe(ioOe)
);

// File: tb/tb_pal_logic_array.sv
module tb_pal_logic_array;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 7;
  localparam int LW = 36;

  logic clk = 1'b0, rst_n = 1'b0, cfgWe = 1'b0;
  logic [AW-1:0] cfgAddr = '0;
  logic [LW-1:0] cfgData = '0;
  logic [9:0] pinIn = '0;
  logic [7:0] ioIn = '0;
  logic [7:0] ioOut, ioOe;

  always #(CLK_PERIOD/2) clk = ~clk;

  pal_logic_array dut (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .pinIn(pinIn), .ioIn(ioIn), .ioOut(ioOut), .ioOe(ioOe)
  );

  int checks = 0, errors = 0;

  // behavioural model state
  logic [LW-1:0] mFuse [64];
  logic [1:0] mMode;
  logic mPdEn;
  logic [7:0] mRegSel, mPol, mQ, mHoldOut, mHoldOe, nQ, nHoldOut, nHoldOe;
  logic mPrev, nPrev;

  function automatic bit cellIsReg(int c);
    return (mMode == 2'd1) || (mMode >= 2'd2 && mRegSel[c]);
  endfunction

  function automatic bit pinIgnored(int k);
    return ((k == 0 || k == 9) && mMode != 2'd0) || (k == 3 && mPdEn);
  endfunction

  function automatic void evalLive(output logic [7:0] o, output logic [7:0] e,
                                   output logic [7:0] d);
    logic [17:0] s;
    for (int k = 0; k < 10; k++) s[k] = pinIn[k];
    for (int c = 0; c < 8; c++) s[10+c] = cellIsReg(c) ? mQ[c] : ioIn[c];
    for (int c = 0; c < 8; c++) begin
      logic orAll, orTail, t0;
      orAll = 0; orTail = 0; t0 = 0;
      for (int tt = 0; tt < 8; tt++) begin
        logic t;
        t = 1;
        for (int j = 0; j < LW; j++) begin
          if (mFuse[c*8+tt][j]) begin
            logic v;
            v = (j % 2 == 0) ? s[j/2] : ~s[j/2];
            if (pinIgnored(j/2)) v = 1;
            t = t & v;
          end
        end
        orAll = orAll | t;
        if (tt == 0) t0 = t; else orTail = orTail | t;
      end
      d[c] = orAll ^ mPol[c];
      if (cellIsReg(c)) begin o[c] = mQ[c]; e[c] = ~pinIn[9]; end
      else begin o[c] = orTail ^ mPol[c]; e[c] = t0; end
    end
  endfunction

  function automatic bit pdNow();
    return mPdEn && pinIn[3];
  endfunction

  function automatic void modelPrepare();
    logic [7:0] o, e, d;
    evalLive(o, e, d);
    nQ = mQ; nHoldOut = mHoldOut; nHoldOe = mHoldOe;
    if (!pdNow()) begin
      nHoldOut = o; nHoldOe = e;
      if (pinIn[0] && !mPrev && mMode != 2'd0)
        for (int c = 0; c < 8; c++) if (cellIsReg(c)) nQ[c] = d[c];
    end
    nPrev = pinIn[0];
  endfunction

  function automatic void modelCommit();
    mQ = nQ; mHoldOut = nHoldOut; mHoldOe = nHoldOe; mPrev = nPrev;
  endfunction

  task automatic checkVec(string tag, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic checkModel(string tag);
    logic [7:0] o, e, d;
    evalLive(o, e, d);
    if (pdNow()) begin o = mHoldOut; e = mHoldOe; end
    checkVec(tag, "ioOut", ioOut, o);
    checkVec(tag, "ioOe", ioOe, e);
  endtask

  task automatic drive(logic [9:0] p, logic [7:0] io, string tag);
    @(negedge clk);
    pinIn = p; ioIn = io;
    #1;
    checkModel(tag);
  endtask

  task automatic endCycle();
    modelPrepare();
    @(posedge clk);
    modelCommit();
  endtask

  task automatic cfgWrite(int addr, logic [LW-1:0] data);
    @(negedge clk);
    cfgWe = 1; cfgAddr = AW'(addr); cfgData = data;
    modelPrepare();
    @(posedge clk);
    modelCommit();
    if (addr < 64) mFuse[addr] = data;
    else if (addr == 64) begin
      mMode = data[1:0]; mPdEn = data[2]; mRegSel = data[10:3]; mPol = data[18:11];
    end
    #1 cfgWe = 0;
  endtask

  function automatic logic [LW-1:0] ctrlWord(logic [1:0] m, logic pd, logic [7:0] rs,
                                             logic [7:0] pl);
    return LW'({pl, rs, pd, m});
  endfunction

  task automatic runRandom(int n, string modeTag);
    bit pdState = 0, pdLast = 0;
    for (int i = 0; i < n; i++) begin
      logic [9:0] p;
      string tag;
      if ($urandom % 10 == 0) pdState = !pdState;
      p = 10'($urandom);
      p[3] = pdState;
      tag = (mPdEn && pdState) ? "R8" : (pdLast ? "R10" : modeTag);
      drive(p, 8'($urandom), tag);
      pdLast = mPdEn && pdState;
      endCycle();
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    for (int r = 0; r < 64; r++) mFuse[r] = '0;
    mMode = 0; mPdEn = 0; mRegSel = 0; mPol = 0;
    mQ = 0; mHoldOut = 0; mHoldOe = 0; mPrev = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    #1;
    checkVec("R1", "ioOut", ioOut, 8'hFF);
    checkVec("R1", "ioOe", ioOe, 8'hFF);
    checkModel("R1");
    endCycle();

    // R2: cell 0, term 0 with every literal -> false; term 1 = pin1 true
    cfgWrite(0, '1);
    cfgWrite(1, LW'(1) << 2);
    for (int r = 2; r < 8; r++) cfgWrite(r, '1);
    drive(10'b0000000010, 8'h00, "R2");
    checkVec("R2", "oe0", {7'b0, ioOe[0]}, 8'h00);
    checkVec("R2", "out0", {7'b0, ioOut[0]}, 8'h01);
    endCycle();
    drive(10'b0000000000, 8'h00, "R2");
    checkVec("R2", "out0", {7'b0, ioOut[0]}, 8'h00);
    endCycle();

    // R3: polarity on cell 0, enable term made empty (true)
    cfgWrite(64, ctrlWord(2'd0, 1'b0, 8'h00, 8'h01));
    cfgWrite(0, '0);
    drive(10'b0000000010, 8'h00, "R3");
    checkVec("R3", "out0", {7'b0, ioOut[0]}, 8'h00);
    checkVec("R3", "oe0", {7'b0, ioOe[0]}, 8'h01);
    endCycle();

    // R7: cell 1 follows pin 3 while power-down is disabled
    cfgWrite(8, '0);
    cfgWrite(9, LW'(1) << 6);
    for (int r = 10; r < 16; r++) cfgWrite(r, '1);
    drive(10'b0000001000, 8'h00, "R7");
    checkVec("R7", "out1", {7'b0, ioOut[1]}, 8'h01);
    endCycle();
    drive(10'b0000000000, 8'h00, "R7");
    checkVec("R7", "out1", {7'b0, ioOut[1]}, 8'h00);
    endCycle();

    // R6 / R8: enable power-down; pin 3 vanishes from the array
    cfgWrite(64, ctrlWord(2'd0, 1'b1, 8'h00, 8'h01));
    drive(10'b0000000010, 8'h00, "R6");
    checkVec("R6", "out1", {7'b0, ioOut[1]}, 8'h01);
    checkVec("R6", "out0", {7'b0, ioOut[0]}, 8'h00);
    endCycle();
    drive(10'b0000001000, 8'h00, "R8");
    checkVec("R8", "out0", {7'b0, ioOut[0]}, 8'h00);
    endCycle();
    drive(10'b0000001010, 8'hFF, "R8");
    checkVec("R8", "out0", {7'b0, ioOut[0]}, 8'h00);
    endCycle();
    drive(10'b0000000000, 8'h00, "R10");
    checkVec("R10", "out0", {7'b0, ioOut[0]}, 8'h01);
    endCycle();

    // R4 / R9 / R10: all registered, cell 2 samples pin 2
    cfgWrite(64, ctrlWord(2'd1, 1'b1, 8'h00, 8'h00));
    cfgWrite(16, LW'(1) << 4);
    for (int r = 17; r < 24; r++) cfgWrite(r, '1);
    drive(10'b0000000100, 8'h00, "R4"); endCycle();
    drive(10'b0000000101, 8'h00, "R4"); endCycle();
    drive(10'b0000000000, 8'h00, "R4");
    checkVec("R4", "out2", {7'b0, ioOut[2]}, 8'h01);
    checkVec("R4", "oe", ioOe, 8'hFF);
    endCycle();
    drive(10'b0000001001, 8'h00, "R9");
    checkVec("R9", "out2", {7'b0, ioOut[2]}, 8'h01);
    endCycle();
    drive(10'b0000000001, 8'h00, "R9");
    checkVec("R9", "out2", {7'b0, ioOut[2]}, 8'h01);
    endCycle();
    drive(10'b0000000000, 8'h00, "R10");
    checkVec("R10", "out2", {7'b0, ioOut[2]}, 8'h01);
    endCycle();
    drive(10'b0000000001, 8'h00, "R4"); endCycle();
    drive(10'b1000000000, 8'h00, "R4");
    checkVec("R4", "out2", {7'b0, ioOut[2]}, 8'h00);
    checkVec("R4", "oe", ioOe, 8'h00);
    endCycle();

    // R5: a write beyond the control word must leave everything unchanged
    cfgWrite(100, '1);
    drive(10'b0000000000, 8'h00, "R5");
    checkVec("R5", "oe", ioOe, 8'hFF);
    endCycle();

    // random fuse maps in each mode
    for (int m = 0; m < 3; m++) begin
      for (int r = 0; r < 64; r++) begin
        logic [LW-1:0] row;
        for (int j = 0; j < LW; j++) row[j] = ($urandom % 14 == 0);
        cfgWrite(r, row);
      end
      cfgWrite(64, ctrlWord(2'(m), 1'($urandom), 8'($urandom), 8'($urandom)));
      runRandom(400, m == 0 ? "R3" : (m == 1 ? "R4" : "R5"));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule